// File: doc/BRIEF.md
# Configuration Image Stream Loader

This block moves a configuration image from a host into a chain of downstream programmable devices. The host sees a small set of 32-bit registers and a data window. It writes the image length in bytes into a length register and turns the engine on. It then delivers the image as 32-bit words, either by writing them itself or by letting an external DMA controller fill the buffer when the engine asks for data. The engine holds the words in an internal FIFO. It sends each word downstream as four bytes over a valid/ready handshake. It counts the bytes it takes in and stops once that count reaches the programmed length.

When the load finishes or fails, the engine latches the cause in its status word and raises an interrupt. The interrupt stays asserted until the host turns the engine off. The same control word also drives an active-low reset line to the downstream devices. Writing enable and reset together, then writing zero, produces one reset pulse. In DMA-paced mode, a request line asks for a burst of half the FIFO depth whenever that much room is free and image bytes are still outstanding.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, irq, dmaReq and cfgValid are low and cfgResetN is high. The control, status, current-count and used registers read 0. The FIFO-size register reads FIFO_WORDS*4 bytes.
- R2: The registers are at these byte offsets: control 0x40, status 0x44, FIFO size 0x48, FIFO used 0x4C, total byte count 0x50, current byte count 0x54. A read returns its value on busRdData in the cycle after busRdEn, and offsets not in this list read 0.
- R3: Control bit 0 is enable, bit 1 is downstream reset and bit 2 is DMA mode. cfgResetN is low exactly while the control register holds both enable and reset, so writing 0x3 and then 0x0 gives one low pulse.
- R4: A control write that sets enable while enable was clear restarts the engine. The restart clears the current byte count, the FIFO and all status flags. Clearing enable leaves the FIFO contents in place.
- R5: Each write to the window at 0x3000 adds one word to the FIFO. The used register reports 4 bytes per word held in the FIFO and reads 0 when the FIFO is empty.
- R6: A word taken from the FIFO goes out as four bytes on cfgByte, most significant byte first. The current byte count rises by 4 for each word taken. No word is taken once the count is at or above the total, so extra words stay in the FIFO.
- R7: When the count has reached the total and the last byte has been accepted, status bit 18 (done) sets and irq rises.
- R8: A window write while the FIFO already holds FIFO_WORDS words at the start of that cycle is dropped, even if a word leaves in the same cycle. The drop sets status bit 1 (overflow), halts streaming and, while enabled, raises irq.
- R9: cfgErrIn high while the engine is active sets status bit 2 (downstream error), halts streaming and raises irq. Any status bit within 0xFFFE other than bit 18 marks an error.
- R10: Once raised, irq stays high until a control write with bit 0 clear.
- R11: dmaReq is high only when enable and DMA mode are set, the engine is active, the current count is below the total, and at least FIFO_WORDS/2 entries are free.
- R12: Status bit 0 reads 1 while the engine is active: enabled, not done and no error flag set. It is not an error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busAddr | input | 16 | Host byte address |
| busWrData | input | 32 | Host write data |
| busRdData | output | 32 | Registered read data |
| irq | output | 1 | Load finished or failed |
| dmaReq | output | 1 | Request for a half-FIFO burst |
| cfgResetN | output | 1 | Active-low reset to downstream devices |
| cfgByte | output | 8 | Image byte to downstream |
| cfgValid | output | 1 | cfgByte is valid |
| cfgReady | input | 1 | Downstream accepts the byte |
| cfgErrIn | input | 1 | Downstream reports a configuration error |

## Verification
The case that needs care is a host push landing in the same cycle as the serializer's pop from a full FIFO. The bench stalls the downstream ready signal until the FIFO holds FIFO_WORDS words and one word sits in the serializer. It then releases ready and times a window write to the exact cycle in which the fourth byte has gone and the next word is popped. The result is judged at the register interface: overflow must be set, the used count must read one word below full, and the current byte count must show both words taken.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  // Host byte offsets
  localparam logic [15:0] ADDR_CTRL   = 16'h0040;
  localparam logic [15:0] ADDR_STAT   = 16'h0044;
  localparam logic [15:0] ADDR_FSIZE  = 16'h0048;
  localparam logic [15:0] ADDR_FUSED  = 16'h004C;
  localparam logic [15:0] ADDR_TOTAL  = 16'h0050;
  localparam logic [15:0] ADDR_CUR    = 16'h0054;
  localparam logic [15:0] ADDR_WINDOW = 16'h3000;

  // Control bits
  localparam int CTRL_EN  = 0;
  localparam int CTRL_RST = 1;
  localparam int CTRL_DMA = 2;

  // Status bits
  localparam int ST_ACTIVE = 0;
  localparam int ST_OVF    = 1;
  localparam int ST_DSERR  = 2;
  localparam int ST_DONE   = 18;

  // Strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic push;
    logic run;
  } dpStrobe_t;
endpackage

// File: rtl/cfgl_fifo.sv
module cfgl_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (level == LW'(DEPTH));
  assign empty  = (level == '0);
  // full is judged on the occupancy at the start of the cycle
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      level <= level + LW'(doPush) - LW'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/cfgl_datapath.sv
module cfgl_datapath
  import cfgl_pkg::*;
#(
  parameter int FIFO_WORDS = 16,
  localparam int LW = $clog2(FIFO_WORDS) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [31:0]   wordIn,
  input  logic [31:0]   totalBytes,
  input  logic          cfgReady,
  output logic [7:0]    cfgByte,
  output logic          cfgValid,
  output logic [31:0]   curBytes,
  output logic [LW-1:0] fifoLevel,
  output logic          fifoFull,
  output logic          drained
);
  localparam int BYTES_PER_WORD = 4;

  logic [31:0] holdWord, fifoOut;
  logic [2:0]  bytesLeft;
  logic        fifoEmpty, popNow;

  assign popNow = strb.run && (bytesLeft == 3'd0) && !fifoEmpty &&
                  (curBytes < totalBytes);

  cfgl_fifo #(.WIDTH(32), .DEPTH(FIFO_WORDS)) u_fifo (
    .clk    (clk),
    .rstN   (rstN),
    .flush  (strb.restart),
    .push   (strb.push),
    .pop    (popNow),
    .wrData (wordIn),
    .rdData (fifoOut),
    .level  (fifoLevel),
    .full   (fifoFull),
    .empty  (fifoEmpty)
  );

  assign cfgValid = strb.run && (bytesLeft != 3'd0);
  assign cfgByte  = holdWord[31:24];
  assign drained  = (curBytes >= totalBytes) && (bytesLeft == 3'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord  <= '0;
      bytesLeft <= '0;
      curBytes  <= '0;
    end else if (strb.restart) begin
      holdWord  <= '0;
      bytesLeft <= '0;
      curBytes  <= '0;
    end else if (popNow) begin
      holdWord  <= fifoOut;
      bytesLeft <= 3'(BYTES_PER_WORD);
      curBytes  <= curBytes + 32'(BYTES_PER_WORD);
    end else if (cfgValid && cfgReady) begin
      holdWord  <= {holdWord[23:0], 8'h00};
      bytesLeft <= bytesLeft - 3'd1;
    end
  end
endmodule

// File: rtl/cfgl_control.sv
module cfgl_control
  import cfgl_pkg::*;
#(
  parameter int FIFO_WORDS = 16,
  localparam int LW = $clog2(FIFO_WORDS) + 1,
  localparam int HALF = FIFO_WORDS / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWrEn,
  input  logic          busRdEn,
  input  logic [15:0]   busAddr,
  input  logic [31:0]   busWrData,
  output logic [31:0]   busRdData,
  input  logic          cfgErrIn,
  input  logic [31:0]   curBytes,
  input  logic [LW-1:0] fifoLevel,
  input  logic          fifoFull,
  input  logic          drained,
  output dpStrobe_t     strb,
  output logic [31:0]   totalBytes,
  output logic          irq,
  output logic          dmaReq,
  output logic          cfgResetN
);
  localparam logic [31:0] FIFO_BYTES = 32'(FIFO_WORDS * 4);

  logic [2:0]  ctrlReg;
  logic        doneFlag, ovfFlag, dsErrFlag;
  logic        ctrlWr, enRise, winWr, active;
  logic        finishNow, overflowNow, dsErrNow, setIrq;
  logic [31:0] statusWord, usedBytes, rdMux;

  assign ctrlWr      = busWrEn && (busAddr == ADDR_CTRL);
  assign winWr       = busWrEn && (busAddr == ADDR_WINDOW);
  assign enRise      = ctrlWr && busWrData[CTRL_EN] && !ctrlReg[CTRL_EN];
  assign active      = ctrlReg[CTRL_EN] && !doneFlag && !ovfFlag && !dsErrFlag;
  assign finishNow   = active && drained;
  assign overflowNow = winWr && fifoFull;
  assign dsErrNow    = active && cfgErrIn;
  assign setIrq      = finishNow || dsErrNow || (overflowNow && ctrlReg[CTRL_EN]);

  assign strb.restart = enRise;
  assign strb.push    = winWr;
  assign strb.run     = active;

  assign cfgResetN = !(ctrlReg[CTRL_EN] && ctrlReg[CTRL_RST]);
  assign dmaReq    = active && ctrlReg[CTRL_DMA] && (curBytes < totalBytes) &&
                     ((LW'(FIFO_WORDS) - fifoLevel) >= LW'(HALF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= '0;
      totalBytes <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= busWrData[2:0];
      if (busWrEn && (busAddr == ADDR_TOTAL)) totalBytes <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
      dsErrFlag <= 1'b0;
    end else if (enRise) begin
      doneFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
      dsErrFlag <= 1'b0;
    end else begin
      if (finishNow)   doneFlag  <= 1'b1;
      if (overflowNow) ovfFlag   <= 1'b1;
      if (dsErrNow)    dsErrFlag <= 1'b1;
    end
  end

  // clearing enable wins over a same-cycle cause
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               irq <= 1'b0;
    else if (ctrlWr && !busWrData[CTRL_EN])  irq <= 1'b0;
    else if (setIrq)                         irq <= 1'b1;
  end

  always_comb begin
    statusWord            = '0;
    statusWord[ST_ACTIVE] = active;
    statusWord[ST_OVF]    = ovfFlag;
    statusWord[ST_DSERR]  = dsErrFlag;
    statusWord[ST_DONE]   = doneFlag;
  end

  assign usedBytes = 32'({fifoLevel, 2'b00});

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL:  rdMux = {29'd0, ctrlReg};
      ADDR_STAT:  rdMux = statusWord;
      ADDR_FSIZE: rdMux = FIFO_BYTES;
      ADDR_FUSED: rdMux = usedBytes;
      ADDR_TOTAL: rdMux = totalBytes;
      ADDR_CUR:   rdMux = curBytes;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        busRdData <= '0;
    else if (busRdEn) busRdData <= rdMux;
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgl_pkg::*;
#(
  parameter int FIFO_WORDS = 16,
  localparam int LW = $clog2(FIFO_WORDS) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [15:0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        irq,
  output logic        dmaReq,
  output logic        cfgResetN,
  output logic [7:0]  cfgByte,
  output logic        cfgValid,
  input  logic        cfgReady,
  input  logic        cfgErrIn
);
  dpStrobe_t     dpStrb;
  logic [31:0]   totalBytes, curBytes;
  logic [LW-1:0] fifoLevel;
  logic          fifoFull, drained;

  cfgl_control #(.FIFO_WORDS(FIFO_WORDS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .cfgErrIn   (cfgErrIn),
    .curBytes   (curBytes),
    .fifoLevel  (fifoLevel),
    .fifoFull   (fifoFull),
    .drained    (drained),
    .strb       (dpStrb),
    .totalBytes (totalBytes),
    .irq        (irq),
    .dmaReq     (dmaReq),
    .cfgResetN  (cfgResetN)
  );

  cfgl_datapath #(.FIFO_WORDS(FIFO_WORDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (dpStrb),
    .wordIn     (busWrData),
    .totalBytes (totalBytes),
    .cfgReady   (cfgReady),
    .cfgByte    (cfgByte),
    .cfgValid   (cfgValid),
    .curBytes   (curBytes),
    .fifoLevel  (fifoLevel),
    .fifoFull   (fifoFull),
    .drained    (drained)
  );
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk
  import cfgl_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [15:0] busAddr,
  input logic        wrBit0,
  input logic        irq,
  input logic        dmaReq,
  input logic        cfgValid,
  input logic        cfgReady,
  input logic [7:0]  cfgByte,
  input logic        cfgErrIn,
  input logic [31:0] curBytes,
  input logic [31:0] totalBytes,
  input logic        fifoFull
);
  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(busWrEn && busAddr == ADDR_CTRL && !wrBit0)) |=> irq);

  assert_dma_room_R11: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> !fifoFull);

  assert_byte_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !cfgReady && !cfgErrIn && !busWrEn) |=> (cfgValid && $stable(cfgByte)));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (curBytes != $past(curBytes)) |-> (curBytes == $past(curBytes) + 32'd4 || curBytes == 32'd0));

  assert_stop_at_total_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((curBytes >= totalBytes) && !busWrEn) |=> $stable(curBytes));

  assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> !cfgValid);
endmodule

bind cfg_stream_loader cfg_stream_loader_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busAddr    (busAddr),
  .wrBit0     (busWrData[0]),
  .irq        (irq),
  .dmaReq     (dmaReq),
  .cfgValid   (cfgValid),
  .cfgReady   (cfgReady),
  .cfgByte    (cfgByte),
  .cfgErrIn   (cfgErrIn),
  .curBytes   (curBytes),
  .totalBytes (totalBytes),
  .fifoFull   (fifoFull)
);

// File: tb/cfg_stream_loader_bench.sv
module cfg_stream_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 16;
  localparam int HALF = FW / 2;
  localparam logic [15:0] A_CTRL = 16'h0040, A_STAT = 16'h0044, A_FSIZE = 16'h0048,
                          A_FUSED = 16'h004C, A_TOTAL = 16'h0050, A_CUR = 16'h0054,
                          A_WIN = 16'h3000;

  typedef struct packed {
    logic        dma;
    logic [7:0]  words;
    logic [15:0] total;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd1,  16'd4},
    '{1'b0, 8'd10, 16'd40},
    '{1'b0, 8'd4,  16'd8},
    '{1'b1, 8'd32, 16'd128},
    '{1'b1, 8'd24, 16'd96},
    '{1'b0, 8'd0,  16'd0}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic irq, dmaReq, cfgResetN, cfgValid;
  logic [7:0] cfgByte;
  logic cfgReady = 1'b0, cfgErrIn = 1'b0;

  int checks = 0, fails = 0;
  int seen = 0, patErr = 0;
  logic monClr = 1'b0, patOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_loader #(.FIFO_WORDS(FW)) u_cfg_stream_loader (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irq(irq), .dmaReq(dmaReq), .cfgResetN(cfgResetN), .cfgByte(cfgByte),
    .cfgValid(cfgValid), .cfgReady(cfgReady), .cfgErrIn(cfgErrIn)
  );

  function automatic logic [7:0] patByte(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] patWord(input int w);
    return {patByte(4*w), patByte(4*w+1), patByte(4*w+2), patByte(4*w+3)};
  endfunction

  // byte monitor: handshake values taken before the edge updates them
  always @(posedge clk) begin
    if (monClr) begin
      seen   <= 0;
      patErr <= 0;
    end else if (cfgValid && cfgReady) begin
      if (patOn && cfgByte !== patByte(seen)) patErr <= patErr + 1;
      seen <= seen + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic clearMon();
    monClr = 1'b1;
    @(negedge clk);
    monClr = 1'b0;
  endtask

  task automatic waitSig(input bit forIrq);
    int n = 0;
    while (((forIrq && !irq) || (!forIrq && !dmaReq)) && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    check("R1 dmaReq", 32'(dmaReq), 32'd0);
    check("R1 cfgValid", 32'(cfgValid), 32'd0);
    check("R1 cfgResetN", 32'(cfgResetN), 32'd1);
    rd(A_FSIZE, v); check("R1 fifo size", v, 32'(FW*4));
    rd(A_FUSED, v); check("R1 used", v, 32'd0);
    rd(A_CTRL, v);  check("R1 ctrl", v, 32'd0);
    rd(A_STAT, v);  check("R1 status", v, 32'd0);
    rd(A_CUR, v);   check("R1 cur", v, 32'd0);
    rd(16'h0058, v); check("R2 unmapped", v, 32'd0);

    // table of loads
    for (int i = 0; i < NVEC; i++) begin
      vec_t t = VECS[i];
      int nw = int'(t.words);
      wr(A_CTRL, 32'd0);
      wr(A_TOTAL, 32'(t.total));
      rd(A_TOTAL, v); check("R2 total readback", v, 32'(t.total));
      clearMon();
      patOn = 1'b1;
      cfgReady = 1'b1;
      wr(A_CTRL, t.dma ? 32'd5 : 32'd1);
      if (!t.dma) begin
        for (int w = 0; w < nw; w++) wr(A_WIN, patWord(w));
      end else begin
        for (int b = 0; b < nw / HALF; b++) begin
          waitSig(1'b0);
          for (int w = 0; w < HALF; w++) wr(A_WIN, patWord(b*HALF + w));
        end
      end
      waitSig(1'b1);
      check("R7 irq on done", 32'(irq), 32'd1);
      rd(A_STAT, v); check("R7 done status", v, 32'h0004_0000);
      rd(A_CUR, v);  check("R6 cur count", v, 32'(t.total));
      check("R6 bytes streamed", 32'(seen), 32'(t.total));
      check("R6 byte order", 32'(patErr), 32'd0);
      rd(A_FUSED, v); check("R5 leftover used", v, 32'(nw*4) - 32'(t.total));
      check("R11 no req after total", 32'(dmaReq), 32'd0);
      repeat (3) @(negedge clk);
      check("R10 irq held", 32'(irq), 32'd1);
      wr(A_CTRL, 32'd0);
      check("R10 irq cleared", 32'(irq), 32'd0);
    end
    patOn = 1'b0;

    // R3 reset pulse
    wr(A_CTRL, 32'd3);
    check("R3 reset low", 32'(cfgResetN), 32'd0);
    rd(A_CTRL, v); check("R3 ctrl readback", v, 32'd3);
    wr(A_CTRL, 32'd0);
    check("R3 reset released", 32'(cfgResetN), 32'd1);
    wr(A_CTRL, 32'd1);
    check("R3 enable alone no reset", 32'(cfgResetN), 32'd1);
    wr(A_CTRL, 32'd0);

    // R11 request gating
    cfgReady = 1'b0;
    wr(A_TOTAL, 32'h400);
    wr(A_CTRL, 32'd1);
    check("R11 no req without dma", 32'(dmaReq), 32'd0);
    wr(A_CTRL, 32'd0);
    wr(A_CTRL, 32'd5);
    check("R11 req when empty", 32'(dmaReq), 32'd1);
    for (int w = 0; w < 10; w++) wr(A_WIN, patWord(w));
    check("R11 no req above half", 32'(dmaReq), 32'd0);
    rd(A_FUSED, v); check("R5 used nine words", v, 32'd36);
    rd(A_STAT, v);  check("R12 active bit", v, 32'd1);
    wr(A_CTRL, 32'd0);

    // R8 overflow coinciding with a pop
    wr(A_CTRL, 32'd1);
    rd(A_FUSED, v); check("R4 flush on enable", v, 32'd0);
    for (int w = 0; w < FW + 1; w++) wr(A_WIN, patWord(w));
    rd(A_FUSED, v); check("R5 full", v, 32'(FW*4));
    cfgReady = 1'b1;
    repeat (4) @(negedge clk);
    wr(A_WIN, 32'hDEAD_BEEF);
    cfgReady = 1'b0;
    rd(A_STAT, v);  check("R8 overflow status", v, 32'd2);
    check("R8 irq", 32'(irq), 32'd1);
    check("R8 halted", 32'(cfgValid), 32'd0);
    rd(A_FUSED, v); check("R8 used after drop", v, 32'((FW-1)*4));
    rd(A_CUR, v);   check("R8 cur count", v, 32'd8);
    wr(A_CTRL, 32'd0);
    rd(A_FUSED, v); check("R4 disable keeps FIFO", v, 32'((FW-1)*4));
    wr(A_CTRL, 32'd1);
    rd(A_FUSED, v); check("R4 restart flush", v, 32'd0);
    rd(A_STAT, v);  check("R4 flags cleared", v, 32'd1);
    rd(A_CUR, v);   check("R4 cur cleared", v, 32'd0);
    wr(A_CTRL, 32'd0);

    // R9 downstream error
    wr(A_TOTAL, 32'd64);
    wr(A_CTRL, 32'd1);
    cfgReady = 1'b1;
    wr(A_WIN, patWord(0));
    wr(A_WIN, patWord(1));
    cfgErrIn = 1'b1;
    @(negedge clk);
    cfgErrIn = 1'b0;
    check("R9 irq", 32'(irq), 32'd1);
    check("R9 halted", 32'(cfgValid), 32'd0);
    rd(A_STAT, v);
    check("R9 status", v, 32'd4);
    check("R9 error mask", 32'((v & 32'hFFFE) != 0), 32'd1);
    wr(A_CTRL, 32'd0);
    check("R10 irq cleared after error", 32'(irq), 32'd0);
    cfgReady = 1'b0;

    repeat (4) @(negedge clk);
    summary();
  end
endmodule